// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two levels of state. The first level records the most recent resolved outcomes as short shift registers. A build parameter picks the form of that record: either one shared register that every branch writes (global history), or sixteen registers, one per branch slot, chosen by PC bits 5:2 (local history). The second level is a table of 256 two-bit saturating counters. Its index is PC bits 5:2 on the upper four bits, joined with the four history bits on the lower four bits. Because the index carries the recorded outcome pattern, the block can learn two kinds of behaviour. In global mode it learns how one branch depends on the branches just before it. In local mode it learns a pattern that repeats within one branch.

The fetch stage presents a PC on the predict port and gets a taken bit back in the same cycle, combinationally. The execute stage reports each resolved branch on the update port. On that clock edge the block moves the addressed counter one step and shifts the outcome into the selected history register. Each counter is a four-state machine: STRONG_NT (0), WEAK_NT (1), WEAK_T (2) and STRONG_T (3). A taken outcome moves it one state toward STRONG_T and stays put at STRONG_T. A not-taken outcome moves it one state toward STRONG_NT and stays put at STRONG_NT. WEAK_T and STRONG_T predict taken.

Top module: `tlp_predictor`

## Requirements
- R1: After reset every counter is WEAK_NT and every history register is zero, so every PC predicts not taken.
- R2: `pred_taken` is 1 exactly when the addressed counter is WEAK_T (2) or STRONG_T (3).
- R3: An update with `upd_taken`=1 moves the addressed counter up by one state and holds it at STRONG_T (3); it never wraps to 0.
- R4: An update with `upd_taken`=0 moves the addressed counter down by one state and holds it at STRONG_NT (0); it never wraps to 3.
- R5: The counter index is {PC[5:2], history}, with PC[5:2] in index bits 7:4 and the history in bits 3:0. PC bits 1:0 and bits 31:6 do not affect the prediction.
- R6: In local mode (GLOBAL_HIST=0) each update shifts only the history register chosen by `upd_pc[5:2]`. The histories of the other fifteen slots stay unchanged.
- R7: In global mode (GLOBAL_HIST=1) every update shifts the one shared history register, so the outcome of one branch changes the counter used by the next branch.
- R8: An update shifts the outcome into history bit 0 (1 = taken), moves the older bits toward bit 3 and drops the oldest one. This happens on the same edge as the counter step, and the counter index is formed from the history as it was before that edge.
- R9: When a prediction and an update arrive in the same cycle, the prediction reflects the state before the update. The updated state is visible from the next cycle on.
- R10: While `upd_valid` is 0, no counter and no history register changes, whatever is on `upd_pc` and `upd_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | 32 | PC of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken (combinational) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
Prediction and update can both occur in the same cycle and can address the same branch. The bench provokes this by setting `pred_pc` and a valid update on the same PC at one falling edge. Just before the next rising edge, it compares `pred_taken` with a bench model that still holds the old counter and history. After that edge, it compares again against the model with the update applied. Both a local-mode instance and a global-mode instance are driven by the same stimulus and compared against a model of each mode. This exposes history that leaks between branch slots and history that fails to carry over between branches.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

    // Two-bit saturating direction counter, one state per encoding.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    // Upper half of the state space predicts taken.
    function automatic logic ctr_says_taken(ctr_e c);
        logic [1:0] v;
        v = c;
        return v[1];
    endfunction

endpackage

// File: rtl/tlp_history_table.sv
module tlp_history_table #(
    parameter int IDX_BITS    = 4,
    parameter int HIST_LEN    = 4,
    parameter bit GLOBAL_HIST = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] pred_sel,
    output logic [HIST_LEN-1:0] pred_hist,
    input  logic                upd_en,
    input  logic [IDX_BITS-1:0] upd_sel,
    input  logic                upd_taken,
    output logic [HIST_LEN-1:0] upd_hist
);

    generate
        if (GLOBAL_HIST) begin : g_global
            logic [HIST_LEN-1:0] ghist_q;
            logic                sel_unused;

            assign sel_unused = ^{pred_sel, upd_sel};

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ghist_q <= '0;
                else if (upd_en)
                    ghist_q <= {ghist_q[HIST_LEN-2:0], upd_taken};
            end

            assign pred_hist = ghist_q;
            assign upd_hist  = ghist_q;

            AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_en |=> $stable(ghist_q)); // R10
            AST_GHIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
                upd_en |=> ghist_q[0] == $past(upd_taken)); // R7
        end else begin : g_local
            localparam int NREG = 1 << IDX_BITS;
            logic [NREG-1:0][HIST_LEN-1:0] lhist_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    lhist_q <= '0;
                else if (upd_en)
                    lhist_q[upd_sel] <= {lhist_q[upd_sel][HIST_LEN-2:0], upd_taken};
            end

            assign pred_hist = lhist_q[pred_sel];
            assign upd_hist  = lhist_q[upd_sel];

            AST_LHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_en |=> $stable(lhist_q)); // R10
            AST_LHIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
                upd_en |=> lhist_q[$past(upd_sel)][0] == $past(upd_taken)); // R8
        end
    endgenerate

endmodule

// File: rtl/tlp_pattern_table.sv
module tlp_pattern_table
    import tlp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_e cnt_q [DEPTH];
    ctr_e cnt_cur;
    ctr_e cnt_nxt;

    assign cnt_cur = cnt_q[wr_idx];

    // Next-state logic of the addressed counter.
    always_comb begin
        unique case (cnt_cur)
            CTR_STRONG_NT: cnt_nxt = wr_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   cnt_nxt = wr_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    cnt_nxt = wr_taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  cnt_nxt = wr_taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       cnt_nxt = CTR_WEAK_NT;
        endcase
    end

    // State register array.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cnt_q[i] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            cnt_q[wr_idx] <= cnt_nxt;
        end
    end

    // Output decode.
    always_comb rd_taken = ctr_says_taken(cnt_q[rd_idx]);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && cnt_cur == CTR_STRONG_T
        |=> cnt_q[$past(wr_idx)] == CTR_STRONG_T); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && cnt_cur == CTR_STRONG_NT
        |=> cnt_q[$past(wr_idx)] == CTR_STRONG_NT); // R4
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && cnt_cur != CTR_STRONG_T
        |=> 2'(cnt_q[$past(wr_idx)]) == 2'(2'($past(cnt_cur)) + 2'd1)); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && cnt_cur != CTR_STRONG_NT
        |=> 2'(cnt_q[$past(wr_idx)]) == 2'(2'($past(cnt_cur)) - 2'd1)); // R4

endmodule

// File: rtl/tlp_predictor.sv
module tlp_predictor #(
    parameter int PC_W        = 32,
    parameter int IDX_LO      = 2,
    parameter int IDX_BITS    = 4,
    parameter int HIST_LEN    = 4,
    parameter bit GLOBAL_HIST = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int IDX_W = IDX_BITS + HIST_LEN;

    logic [IDX_BITS-1:0] pred_sel;
    logic [IDX_BITS-1:0] upd_sel;
    logic [HIST_LEN-1:0] pred_hist;
    logic [HIST_LEN-1:0] upd_hist;
    logic [IDX_W-1:0]    pred_idx;
    logic [IDX_W-1:0]    upd_idx;
    logic                pc_unused;

    assign pred_sel  = pred_pc[IDX_LO +: IDX_BITS];
    assign upd_sel   = upd_pc[IDX_LO +: IDX_BITS];
    assign pc_unused = ^{pred_pc, upd_pc};

    tlp_history_table #(
        .IDX_BITS    (IDX_BITS),
        .HIST_LEN    (HIST_LEN),
        .GLOBAL_HIST (GLOBAL_HIST)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .pred_sel  (pred_sel),
        .pred_hist (pred_hist),
        .upd_en    (upd_valid),
        .upd_sel   (upd_sel),
        .upd_taken (upd_taken),
        .upd_hist  (upd_hist)
    );

    assign pred_idx = {pred_sel, pred_hist};
    assign upd_idx  = {upd_sel, upd_hist};

    tlp_pattern_table #(
        .IDX_W (IDX_W)
    ) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_taken (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    AST_RESET_PRED: assert property (@(posedge clk)
        $rose(rst_n) |-> !pred_taken); // R1

endmodule

// File: tb/sim_tlp_predictor.sv
module sim_tlp_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        pt_loc;
    logic        pt_glb;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model: [0] local mode, [1] global mode.
    int m_cnt [2][256];
    int m_hist[2][16];

    always #5 clk = ~clk;

    tlp_predictor #(.GLOBAL_HIST(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_loc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    tlp_predictor #(.GLOBAL_HIST(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_glb),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    function automatic int m_sel(int mode, logic [31:0] pc);
        return (mode == 1) ? 0 : int'(pc[5:2]);
    endfunction

    function automatic int m_idx(int mode, logic [31:0] pc);
        return int'(pc[5:2]) * 16 + m_hist[mode][m_sel(mode, pc)];
    endfunction

    function automatic int m_pred(int mode, logic [31:0] pc);
        return (m_cnt[mode][m_idx(mode, pc)] >= 2) ? 1 : 0;
    endfunction

    function automatic void m_reset();
        for (int md = 0; md < 2; md++) begin
            for (int i = 0; i < 256; i++) m_cnt[md][i] = 1;
            for (int i = 0; i < 16; i++) m_hist[md][i] = 0;
        end
    endfunction

    function automatic void m_update(logic [31:0] pc, bit t);
        for (int md = 0; md < 2; md++) begin
            int ix = m_idx(md, pc);
            int s = m_sel(md, pc);
            if (t && m_cnt[md][ix] < 3) m_cnt[md][ix]++;
            if (!t && m_cnt[md][ix] > 0) m_cnt[md][ix]--;
            m_hist[md][s] = ((m_hist[md][s] << 1) | int'(t)) & 15;
        end
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Both instances against the model for one PC.
    task automatic chk_pc(string req, logic [31:0] pc);
        @(negedge clk);
        pred_pc = pc;
        #1;
        chk({req, " local"}, int'(pt_loc), m_pred(0, pc));
        chk({req, " global"}, int'(pt_glb), m_pred(1, pc));
    endtask

    task automatic upd(logic [31:0] pc, bit t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc = pc;
        upd_taken = t;
        @(posedge clk);
        #1;
        m_update(pc, t);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) begin
            chk_pc("R1", 32'(i * 4));
            chk("R1 const", int'(pt_loc | pt_glb), 0);
        end
    endtask

    task automatic t_saturate_up();
        for (int i = 0; i < 4; i++) upd(32'h10, 1'b1);
        for (int i = 0; i < 5; i++) upd(32'h24, 1'b1);
        upd(32'h24, 1'b0);
        for (int i = 0; i < 4; i++) upd(32'h10, 1'b1);
        chk_pc("R3", 32'h24);
        chk("R3 no wrap", int'(pt_glb), 1);
        upd(32'h24, 1'b0);
        for (int i = 0; i < 4; i++) upd(32'h10, 1'b1);
        chk_pc("R2", 32'h24);
        chk("R2 weak_nt", int'(pt_glb), 0);
    endtask

    task automatic t_saturate_down();
        for (int i = 0; i < 4; i++) upd(32'h10, 1'b0);
        for (int i = 0; i < 4; i++) upd(32'h28, 1'b0);
        upd(32'h28, 1'b1);
        for (int i = 0; i < 4; i++) upd(32'h10, 1'b0);
        chk_pc("R4", 32'h28);
        chk("R4 no wrap", int'(pt_glb), 0);
        upd(32'h28, 1'b1);
        for (int i = 0; i < 4; i++) upd(32'h10, 1'b0);
        chk_pc("R2", 32'h28);
        chk("R2 weak_t", int'(pt_glb), 1);
    endtask

    task automatic t_pc_bits();
        for (int i = 0; i < 6; i++) upd(32'h3C, 1'b1);
        chk_pc("R5", 32'h3C);
        chk("R5 alias local", int'(pt_loc), 1);
        chk_pc("R5", 32'hFFFF_FFFF);
        chk("R5 alias hi", int'(pt_loc), 1);
        chk_pc("R5", 32'h0000_0038);
        chk("R5 other slot", int'(pt_loc), 0);
    endtask

    task automatic t_local_isolation();
        for (int i = 0; i < 6; i++) upd(32'h08, 1'b1);
        chk_pc("R6", 32'h08);
        chk("R6 before", int'(pt_loc), 1);
        upd(32'h0C, 1'b0);
        upd(32'h0C, 1'b0);
        chk_pc("R6", 32'h08);
        chk("R6 after", int'(pt_loc), 1);
    endtask

    task automatic t_global_corr();
        for (int r = 0; r < 8; r++) begin
            upd(32'h14, 1'b1);
            upd(32'h18, 1'b1);
            upd(32'h14, 1'b0);
            upd(32'h18, 1'b0);
        end
        upd(32'h14, 1'b1);
        chk_pc("R7", 32'h18);
        chk("R7 follows taken", int'(pt_glb), 1);
        upd(32'h18, 1'b1);
        upd(32'h14, 1'b0);
        chk_pc("R7", 32'h18);
        chk("R7 follows not", int'(pt_glb), 0);
    endtask

    task automatic t_hist_order();
        // Pattern T,N,N,N repeated on one slot: history before the T is 1000.
        for (int r = 0; r < 4; r++) begin
            upd(32'h30, 1'b1);
            upd(32'h30, 1'b0);
            upd(32'h30, 1'b0);
            upd(32'h30, 1'b0);
        end
        chk_pc("R8", 32'h30);
        chk("R8 order", int'(pt_loc), 1);
        upd(32'h30, 1'b1);
        chk_pc("R8", 32'h30);
    endtask

    task automatic t_same_cycle();
        for (int i = 0; i < 3; i++) upd(32'h20, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            pred_pc = 32'h20;
            upd_valid = 1'b1;
            upd_pc = 32'h20;
            upd_taken = 1'b1;
            #1;
            chk("R9 pre local", int'(pt_loc), m_pred(0, 32'h20));
            chk("R9 pre global", int'(pt_glb), m_pred(1, 32'h20));
            @(posedge clk);
            #1;
            m_update(32'h20, 1'b1);
            chk("R9 post local", int'(pt_loc), m_pred(0, 32'h20));
            chk("R9 post global", int'(pt_glb), m_pred(1, 32'h20));
            @(negedge clk);
            upd_valid = 1'b0;
        end
    endtask

    task automatic t_idle_update();
        @(negedge clk);
        upd_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            upd_pc = 32'(i * 4);
            upd_taken = i[0];
            @(negedge clk);
        end
        for (int i = 0; i < 16; i++) chk_pc("R10", 32'(i * 4));
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_saturate_up();
        t_saturate_down();
        t_pc_bits();
        t_local_isolation();
        t_global_corr();
        t_hist_order();
        t_same_cycle();
        t_idle_update();
        for (int i = 0; i < 16; i++) chk_pc("R2 sweep", 32'(i * 4 + 1));
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule